// File: doc/BRIEF.md
# Delta-Sigma Readout Sequencer

This block holds the digital control and readout for a delta-sigma converter that sleeps between results. From reset it runs a conversion, modelled as a countdown whose length depends on the selected speed setting. It then parks in a low-power sleep phase and waits for the host to pull the chip select low. While the select is low it shifts a 32-bit result word out on a serial data line. The clock for that transfer is either supplied by the host on the clock pin or generated by the block and driven out on the same pin. A mode input chooses between the two.

While the result leaves, the host feeds a four-bit speed code in on the serial input. A static level on that input is also a valid code. The code sets the length of the very next conversion. If the host raises the select before the word is complete, the readout is dropped and a fresh conversion starts at once. A busy flag is high exactly while a conversion runs. When the select is low outside a readout, the serial output shows conversion status.

Top module: `dsig_seq_ctrl`

## Requirements
- R1: Under reset `busy` is 1, `sck_out` is 0 and `sdo_oe` is 0 while `cs_n` is high. The first conversion after reset uses setting 0 and lasts exactly CONV_BASE cycles.
- R2: A conversion at setting s keeps `busy` high for exactly CONV_BASE*(s+1) clock cycles. Then `busy` falls and the block enters sleep.
- R3: In sleep with `cs_n` high, the block stays asleep. `busy` stays 0, `sdo_oe` stays 0 and no shift clock is produced.
- R4: `sdo_oe` is 1 exactly when `cs_n` is 0. Low `cs_n` in sleep starts the readout on the next clock.
- R5: With `cs_n` low and no readout in progress, `sdo` carries the status: 1 while converting and 0 while asleep.
- R6: The readout word is 32 bits, sent most significant bit first. Bit 31 is 0 and bits 30..0 equal `sample`. `sdo` moves to the next bit after each falling shift-clock edge. `sdi` is sampled on each rising edge.
- R7: With `ext_sel` = 0, `sck_oe` is 0, `sck_out` stays 0, and shifting follows the edges seen on `sck_in`.
- R8: With `ext_sel` = 1, `sck_oe` is 1. The block drives exactly 32 pulses on `sck_out` with a period of 2*SCK_HALF cycles. The rising edges are evenly spaced.
- R9: The speed code is the four `sdi` bits taken on the first four rising edges, first bit being the code MSB. Codes 1..9 select the setting of that number, code 15 selects setting 9 (slowest), and codes 0 and 10..14 select setting 0. The code governs the conversion that follows the readout.
- R10: Raising `cs_n` during a readout makes `busy` high on the next clock and starts a full conversion. A code is applied only if all four of its bits were taken before the abort. Otherwise the previous setting is kept.
- R11: After the 32nd falling shift-clock edge the readout ends and `busy` returns high without any action on `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, synchronous to `clk` |
| sdi | input | 1 | Serial speed-code input |
| ext_sel | input | 1 | Shift clock source: 0 host-supplied, 1 generated |
| sck_in | input | 1 | Host-supplied shift clock (asynchronous) |
| sck_out | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Drive enable for the shift clock pin |
| sample | input | WORD_W-1 | Parallel result from the stand-in modulator |
| busy | output | 1 | High while a conversion runs |
| sdo | output | 1 | Serial data or status |
| sdo_oe | output | 1 | Drive enable for `sdo` |

## Verification
The assertions assume that `cs_n` is synchronous to `clk` and changes only between edges. They also assume the host shift clock idles low when a readout begins, and that `ext_sel` and `sample` stay steady throughout a readout. The bench drives every input on the falling edge of `clk` and changes `ext_sel` only while the block sleeps. It starts each host clock from low and holds every host clock level for six system cycles, which covers the synchronizer delay, so no edge is lost or doubled.

// File: rtl/dsig_seq_pkg.sv
package dsig_seq_pkg;

    localparam int CODE_W       = 4;
    localparam int NUM_SETTINGS = 10;
    localparam int SET_W        = 4;
    localparam int SLOW_SET     = NUM_SETTINGS - 1;

    typedef enum logic [1:0] {
        PH_CONV  = 2'd0,
        PH_SLEEP = 2'd1,
        PH_OUT   = 2'd2
    } phase_e;

    // Map a captured speed code onto a setting index.
    function automatic logic [SET_W-1:0] code_to_set(input logic [CODE_W-1:0] code);
        logic [SET_W-1:0] s;
        if (code == {CODE_W{1'b1}}) begin
            s = SET_W'(SLOW_SET);
        end else if (code < CODE_W'(NUM_SETTINGS)) begin
            s = SET_W'(code);
        end else begin
            s = '0;
        end
        return s;
    endfunction

endpackage

// File: rtl/dsig_conv_timer.sv
module dsig_conv_timer #(
    parameter int LEN_W   = 8,
    parameter int RST_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic             expired
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = len - LEN_W'(1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= LEN_W'(RST_LEN - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = (st_q.cnt == '0);

endmodule

// File: rtl/dsig_sck_unit.sv
module dsig_sck_unit #(
    parameter int SCK_HALF    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic int_mode,
    input  logic sck_in,
    output logic rise,
    output logic fall,
    output logic sck_out
);

    localparam int HALF_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   level;
        logic [HALF_W-1:0]      div;
    } sck_t;

    sck_t st_d, st_q;
    logic [SYNC_STAGES-1:0] sync_next;
    logic                   sync_out;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            assign sync_next = sck_in;
        end else begin : g_sync_chain
            assign sync_next = {st_q.sync[SYNC_STAGES-2:0], sck_in};
        end
    endgenerate

    assign sync_out = st_q.sync[SYNC_STAGES-1];

    logic div_end;
    logic gen_on;
    logic ext_rise, ext_fall;
    logic gen_rise, gen_fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = sync_next;
        st_d.prev = sync_out;

        gen_on  = active && int_mode;
        div_end = (st_q.div == HALF_W'(SCK_HALF - 1));

        if (gen_on) begin
            if (div_end) begin
                st_d.div   = '0;
                st_d.level = !st_q.level;
            end else begin
                st_d.div = st_q.div + HALF_W'(1);
            end
        end else begin
            st_d.div   = '0;
            st_d.level = 1'b0;
        end

        ext_rise = active && !int_mode && sync_out && !st_q.prev;
        ext_fall = active && !int_mode && !sync_out && st_q.prev;
        gen_rise = gen_on && div_end && !st_q.level;
        gen_fall = gen_on && div_end && st_q.level;

        rise = ext_rise || gen_rise;
        fall = ext_fall || gen_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_out = st_q.level && active && int_mode;

endmodule

// File: rtl/dsig_shift_out.sv
module dsig_shift_out
    import dsig_seq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-2:0] sample,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    output logic              sdo_bit,
    output logic              done,
    output logic [CODE_W-1:0] code,
    output logic              code_full
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  nrise;
        logic [CNT_W-1:0]  nfall;
        logic [CODE_W-1:0] code;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.shreg = {1'b0, sample};
            st_d.nrise = '0;
            st_d.nfall = '0;
            st_d.code  = '0;
        end else begin
            if (rise && (st_q.nrise != CNT_W'(WORD_W))) begin
                st_d.nrise = st_q.nrise + CNT_W'(1);
                if (st_q.nrise < CNT_W'(CODE_W)) begin
                    st_d.code = {st_q.code[CODE_W-2:0], sdi};
                end
            end
            if (fall && (st_q.nfall != CNT_W'(WORD_W))) begin
                st_d.shreg = {st_q.shreg[WORD_W-2:0], 1'b0};
                st_d.nfall = st_q.nfall + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_bit   = st_q.shreg[WORD_W-1];
    assign done      = fall && !load && (st_q.nfall == CNT_W'(WORD_W - 1));
    assign code      = st_q.code;
    assign code_full = (st_q.nrise >= CNT_W'(CODE_W));

endmodule

// File: rtl/dsig_seq_ctrl.sv
module dsig_seq_ctrl
    import dsig_seq_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int CONV_BASE   = 16,
    parameter int SCK_HALF    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              ext_sel,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic [WORD_W-2:0] sample,
    output logic              busy,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int LEN_W = $clog2(CONV_BASE * NUM_SETTINGS + 1);

    typedef struct packed {
        phase_e           phase;
        logic [SET_W-1:0] rate;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              shift_load;
    logic              tmr_load;
    logic [LEN_W-1:0]  tmr_len;
    logic              tmr_expired;
    logic              rise, fall;
    logic              sdo_bit;
    logic              shift_done;
    logic [CODE_W-1:0] code;
    logic              code_full;
    logic [SET_W-1:0]  next_set;
    logic              in_out;
    phase_e            phase_w;

    assign in_out  = (st_q.phase == PH_OUT);
    assign phase_w = st_q.phase;

    always_comb begin
        st_d       = st_q;
        shift_load = 1'b0;
        tmr_load   = 1'b0;
        next_set   = code_full ? code_to_set(code) : st_q.rate;
        tmr_len    = LEN_W'(CONV_BASE) * (LEN_W'(next_set) + LEN_W'(1));

        case (st_q.phase)
            PH_CONV: begin
                if (tmr_expired) begin
                    st_d.phase = PH_SLEEP;
                end
            end
            PH_SLEEP: begin
                if (!cs_n) begin
                    st_d.phase = PH_OUT;
                    shift_load = 1'b1;
                end
            end
            PH_OUT: begin
                if (cs_n || shift_done) begin
                    st_d.phase = PH_CONV;
                    st_d.rate  = next_set;
                    tmr_load   = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_CONV;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_CONV;
            st_q.rate  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dsig_conv_timer #(
        .LEN_W  (LEN_W),
        .RST_LEN(CONV_BASE)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .len    (tmr_len),
        .expired(tmr_expired)
    );

    dsig_sck_unit #(
        .SCK_HALF   (SCK_HALF),
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_out),
        .int_mode(ext_sel),
        .sck_in  (sck_in),
        .rise    (rise),
        .fall    (fall),
        .sck_out (sck_out)
    );

    dsig_shift_out #(
        .WORD_W(WORD_W)
    ) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (shift_load),
        .sample   (sample),
        .rise     (rise),
        .fall     (fall),
        .sdi      (sdi),
        .sdo_bit  (sdo_bit),
        .done     (shift_done),
        .code     (code),
        .code_full(code_full)
    );

    assign busy   = (st_q.phase == PH_CONV);
    assign sdo    = in_out ? sdo_bit : busy;
    assign sdo_oe = !cs_n;
    assign sck_oe = ext_sel;

endmodule

// File: rtl/dsig_seq_ctrl_chk.sv
module dsig_seq_ctrl_chk
    import dsig_seq_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   cs_n,
    input logic   ext_sel,
    input logic   busy,
    input logic   sdo,
    input logic   sdo_oe,
    input logic   sck_out,
    input phase_e phase
);

    // R4: the data pin is released whenever the chip is deselected
    a_r4_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdo_oe);

    // R3: sleep persists while deselected
    a_r3_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLEEP && cs_n) |=> (phase == PH_SLEEP && !busy));

    // R10: deselect during readout restarts conversion on the next clock
    a_r10_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OUT && cs_n) |=> (phase == PH_CONV && busy));

    // R11: busy only rises when a readout ends
    a_r11_busy_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(phase) == PH_OUT));

    // R2: busy only falls into sleep
    a_r2_busy_fall_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (phase == PH_SLEEP));

    // R8: no generated clock outside a readout
    a_r8_no_clock_outside_readout: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_OUT) |-> !sck_out);

    // R7: no generated clock in host-clock mode
    a_r7_quiet_in_host_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_sel |-> !sck_out);

    // R5: status reads high during conversion
    a_r5_status_converting: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV && !cs_n) |-> sdo);

endmodule

bind dsig_seq_ctrl dsig_seq_ctrl_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .ext_sel(ext_sel),
    .busy   (busy),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .sck_out(sck_out),
    .phase  (phase_w)
);

// File: tb/test_dsig_seq_ctrl.sv
`timescale 1ns/1ps
module test_dsig_seq_ctrl;

    localparam int WORD_W    = 32;
    localparam int CONV_BASE = 16;
    localparam int SCK_HALF  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              sdi = 1'b0;
    logic              ext_sel = 1'b0;
    logic              sck_in = 1'b0;
    logic              sck_out, sck_oe, busy, sdo, sdo_oe;
    logic [WORD_W-2:0] sample = '0;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dsig_seq_ctrl #(
        .WORD_W   (WORD_W),
        .CONV_BASE(CONV_BASE),
        .SCK_HALF (SCK_HALF)
    ) i_dsig_seq_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sdi    (sdi),
        .ext_sel(ext_sel),
        .sck_in (sck_in),
        .sck_out(sck_out),
        .sck_oe (sck_oe),
        .sample (sample),
        .busy   (busy),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input int code);
        int s;
        if (code == 15) s = 9;
        else if (code <= 9) s = code;
        else s = 0;
        return CONV_BASE * (s + 1);
    endfunction

    // Counts busy-high cycles; optionally checks status and deselects early.
    task automatic measure(input bit drop_cs, output int wait_n, output int len);
        wait_n = 0;
        len = 0;
        while (!busy && wait_n < 60) begin
            @(negedge clk);
            wait_n++;
        end
        while (busy && len < 5000) begin
            if (drop_cs && len == 0) begin
                chk(sdo_oe && sdo, "R5", "status while converting", sdo, 1);
                cs_n = 1'b1;
            end
            if (drop_cs && len == 1) chk(!sdo_oe, "R4", "oe after deselect", sdo_oe, 0);
            len++;
            @(negedge clk);
        end
    endtask

    task automatic host_bit(input bit d, input bit last);
        sdi = d;
        sck_in = 1'b1;
        repeat (6) @(negedge clk);
        sck_in = 1'b0;
        if (!last) repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
        chk(!sdo_oe, "R1", "oe in reset", sdo_oe, 0);
        chk(!sck_out && !sck_oe, "R1", "clock pin in reset", sck_out, 0);
    endtask

    task automatic t_first_conv();
        int w, n;
        rst_n = 1'b1;
        measure(1'b0, w, n);
        chk(n == CONV_BASE, "R1", "first conversion length", n, CONV_BASE);
    endtask

    task automatic t_host_readout(input int code, input bit tail, input logic [WORD_W-2:0] val);
        logic [WORD_W-1:0] word;
        int errs, w, n;
        bit d;
        sample = val;
        word = {1'b0, val};
        errs = 0;
        cs_n = 1'b0;
        #1;
        chk(sdo_oe && !sdo, "R5", "status while asleep", sdo, 0);
        repeat (2) @(negedge clk);
        chk(!busy, "R4", "readout started, busy low", busy, 0);
        for (int i = 0; i < WORD_W; i++) begin
            if (sdo !== word[WORD_W-1-i]) errs++;
            if (sck_oe || sck_out) errs++;
            d = (i < 4) ? code[3-i] : tail;
            host_bit(d, i == WORD_W - 1);
        end
        chk(errs == 0, "R6", "host-clock word bit errors", errs, 0);
        chk(errs == 0, "R7", "host-clock mode pin quiet", errs, 0);
        measure(1'b1, w, n);
        chk(w <= 4, "R11", "busy return after last edge", w, 3);
        chk(n == exp_len(code), "R9", $sformatf("length for code %0d", code), n, exp_len(code));
    endtask

    task automatic t_sleep_hold();
        int errs;
        errs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (busy || sdo_oe || sck_out) errs++;
        end
        chk(errs == 0, "R3", "sleep disturbances", errs, 0);
    endtask

    task automatic t_int_readout(input int code, input logic [WORD_W-2:0] val);
        logic [WORD_W-1:0] word;
        int rises, last_t, cyc, bit_err, per_err, w, n;
        bit prev;
        sample = val;
        word = {1'b0, val};
        ext_sel = 1'b1;
        sdi = code[3];
        rises = 0; last_t = 0; cyc = 0; bit_err = 0; per_err = 0; prev = 1'b0;
        @(negedge clk);
        chk(sck_oe == 1'b1, "R8", "clock pin driven", sck_oe, 1);
        cs_n = 1'b0;
        while (cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (busy) break;
            if (sck_out && !prev) begin
                if (rises < WORD_W && sdo !== word[WORD_W-1-rises]) bit_err++;
                if (rises > 0 && (cyc - last_t) != 2 * SCK_HALF) per_err++;
                last_t = cyc;
                rises++;
                sdi = (rises < 4) ? code[3-rises] : 1'b0;
            end
            prev = sck_out;
        end
        chk(rises == WORD_W, "R8", "generated pulse count", rises, WORD_W);
        chk(per_err == 0, "R8", "pulse spacing errors", per_err, 0);
        chk(bit_err == 0, "R6", "generated-clock word bit errors", bit_err, 0);
        measure(1'b1, w, n);
        chk(n == exp_len(code), "R9", $sformatf("length after generated readout code %0d", code),
            n, exp_len(code));
        @(negedge clk);
        ext_sel = 1'b0;
    endtask

    task automatic t_abort(input int nbits, input int code, input int exp_n);
        int w, n;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            host_bit((i < 4) ? code[3-i] : 1'b0, 1'b0);
        end
        cs_n = 1'b1;
        measure(1'b0, w, n);
        chk(w == 1, "R10", "busy one clock after abort", w, 1);
        chk(n == exp_n, "R10", $sformatf("length after abort with %0d bits", nbits), n, exp_n);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        t_first_conv();
        t_host_readout(0, 1'b0, 31'h5A5A_1234);
        t_host_readout(5, 1'b0, 31'h0F0F_00FF);
        t_sleep_hold();
        t_host_readout(12, 1'b0, 31'h7FFF_FFFF);
        t_host_readout(15, 1'b1, 31'h1357_9BDF);   // static high on sdi
        t_int_readout(3, 31'h2468_ACE0);
        t_abort(2, 9, exp_len(3));                 // partial code is discarded
        t_abort(5, 9, exp_len(9));                 // full code is applied
        t_host_readout(0, 1'b0, 31'h0000_0001);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule